// File: doc/BRIEF.md
# Three-Accumulator 16-bit Processor Core

This core is a compact 16-bit processor built around an accumulator, with one difference from the classic design: it has three accumulators, not one. Arithmetic, logic, load and store instructions never name a register. They always work on whichever accumulator is currently active. A select instruction switches the active accumulator, so software can set a partial result aside and pick it up again later without storing it to data memory and loading it back.

Each instruction goes through a short sequence of phases: fetch, decode, execute, and an extra writeback phase for instructions that read data memory. Instructions come from a synchronous, word-addressed program memory. A second synchronous port reads and writes data memory. The top bit of the instruction word sets the decode format. When it is set, the word is a control transfer with a 3-bit code and a 13-bit signed displacement. When it is clear, the word is an operation with a 5-bit code and an 11-bit operand.

Top module: `acc3_core`

## Requirements
- R1: While reset is asserted, and right after it is released, `imem_addr` is 0, `halted` is 0, and neither data strobe is asserted. All three accumulators hold 0 and accumulator 0 is active. The first phase after reset is a fetch (`imem_en` = 1).
- R2: Bit 15 set selects a control transfer: bits 15..13 give the code (100 jump, 101 branch-if-zero, 110 branch-if-negative, 111 branch-if-nonzero) and bits 12..0 give a signed displacement. Bit 15 clear selects an operation: bits 15..11 give the code (00001 load, 00010 load-immediate, 00011 store, 00100 add, 00101 subtract, 00110 and, 00111 or, 01000 select, 01111 halt) and bits 10..0 give the operand.
- R3: `imem_en` is high for one cycle at the start of each instruction and the word arrives the next cycle. An instruction that reads data memory (load, add, subtract, and, or) takes 4 cycles. Every other instruction takes 3. A store drives `dmem_we` during its third cycle.
- R4: Load-immediate writes the zero-extended 11-bit operand into the active accumulator.
- R5: Load, add, subtract, and, and or read data memory at the operand address. They write the loaded value, or the modulo-2^16 result of combining it with the active accumulator, back into the active accumulator.
- R6: A store drives the active accumulator's value on `dmem_wdata` to the operand address, with `dmem_we` high for exactly one cycle. Reads and writes are never requested in the same cycle.
- R7: Select makes the accumulator named by operand bits 1..0 active (0, 1 or 2). The value 3 leaves the active choice unchanged. Accumulators that are not active never change.
- R8: A taken transfer continues at the transfer's own address plus the sign-extended 13-bit displacement. Both forward and backward targets are supported.
- R9: A branch is taken when the active accumulator is zero (101), has bit 15 set (110), or is nonzero (111). When it is not taken, execution continues at the next word.
- R10: Halt raises `halted` three cycles after its fetch. `halted` then stays high until reset, and no further fetch or data access takes place.
- R11: Operation codes not listed in R2 have no effect other than taking 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_en | output | 1 | Program memory read request |
| imem_addr | output | IADDR_W | Program counter / program memory address |
| imem_rdata | input | 16 | Program word, valid one cycle after the request |
| dmem_re | output | 1 | Data memory read request |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | 11 | Data memory word address |
| dmem_wdata | output | 16 | Data written on a store |
| dmem_rdata | input | 16 | Data read, valid one cycle after `dmem_re` |
| halted | output | 1 | Core has executed halt |

## Verification
An instruction that starts at cycle t fetches at t. Its store strobe appears at t+2. It finishes at t+3, or at t+4 if it reads data memory. A halt raises `halted` at t+3. The bench runs an instruction-level model of the requirements and turns each instruction into a cycle budget. It then predicts the exact cycle of every store and of the halt, and compares the design against those predictions. Outputs are sampled on the falling edge after each counted rising edge, so every registered result is read in the cycle it is due.

// File: rtl/acc3_pkg.sv
package acc3_pkg;
    localparam int XLEN  = 16;
    localparam int OPR_W = 11;
    localparam int OFF_W = 13;

    localparam logic [4:0] OPC_LD   = 5'b00001;
    localparam logic [4:0] OPC_LDI  = 5'b00010;
    localparam logic [4:0] OPC_ST   = 5'b00011;
    localparam logic [4:0] OPC_ADD  = 5'b00100;
    localparam logic [4:0] OPC_SUB  = 5'b00101;
    localparam logic [4:0] OPC_AND  = 5'b00110;
    localparam logic [4:0] OPC_OR   = 5'b00111;
    localparam logic [4:0] OPC_SEL  = 5'b01000;
    localparam logic [4:0] OPC_HALT = 5'b01111;

    localparam logic [2:0] JOP_JMP = 3'b100;
    localparam logic [2:0] JOP_BZ  = 3'b101;
    localparam logic [2:0] JOP_BN  = 3'b110;
    localparam logic [2:0] JOP_BNZ = 3'b111;

    typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_WB, S_HALT} phase_e;
    typedef enum logic [2:0] {ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
    typedef enum logic [1:0] {C_ALWAYS, C_ZERO, C_NEG, C_NONZERO} cond_e;

    typedef struct packed {
        logic    br;
        cond_e   cond;
        logic    ldi;
        logic    rd;
        logic    st;
        logic    sel;
        logic    halt;
        alu_op_e alu;
    } ctl_t;
endpackage

// File: rtl/acc3_decode.sv
module acc3_decode
    import acc3_pkg::*;
(
    input  logic [4:0] head,
    output ctl_t       ctl
);
    always_comb begin
        ctl      = '0;
        ctl.cond = C_ALWAYS;
        ctl.alu  = ALU_PASS;
        if (head[4]) begin
            ctl.br = 1'b1;
            case (head[4:2])
                JOP_BZ:  ctl.cond = C_ZERO;
                JOP_BN:  ctl.cond = C_NEG;
                JOP_BNZ: ctl.cond = C_NONZERO;
                default: ctl.cond = C_ALWAYS;
            endcase
        end else begin
            case (head)
                OPC_LD:   ctl.rd = 1'b1;
                OPC_LDI:  ctl.ldi = 1'b1;
                OPC_ST:   ctl.st = 1'b1;
                OPC_ADD:  begin ctl.rd = 1'b1; ctl.alu = ALU_ADD; end
                OPC_SUB:  begin ctl.rd = 1'b1; ctl.alu = ALU_SUB; end
                OPC_AND:  begin ctl.rd = 1'b1; ctl.alu = ALU_AND; end
                OPC_OR:   begin ctl.rd = 1'b1; ctl.alu = ALU_OR;  end
                OPC_SEL:  ctl.sel = 1'b1;
                OPC_HALT: ctl.halt = 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/acc3_alu.sv
module acc3_alu
    import acc3_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc3_accbank.sv
module acc3_accbank #(
    parameter  int NACC = 3,
    parameter  int W    = 16,
    localparam int IW   = $clog2(NACC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic                     sel_en,
    input  logic [IW-1:0]            sel_idx,
    output logic [IW-1:0]            act_idx,
    output logic [NACC-1:0][W-1:0]   acc_all
);
    logic [IW-1:0]          act_d, act_q;
    logic [NACC-1:0][W-1:0] acc_d, acc_q;

    always_comb begin
        act_d = act_q;
        if (sel_en && (int'(sel_idx) < NACC)) begin
            act_d = sel_idx;
        end
        for (int i = 0; i < NACC; i++) begin
            acc_d[i] = (wr_en && int'(act_q) == i) ? wr_data : acc_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            acc_q <= '0;
        end else begin
            act_q <= act_d;
            acc_q <= acc_d;
        end
    end

    assign act_idx = act_q;
    assign acc_all = acc_q;
endmodule

// File: rtl/acc3_core.sv
module acc3_core
    import acc3_pkg::*;
#(
    parameter int IADDR_W = 16,
    parameter int NACC    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               imem_en,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [XLEN-1:0]    imem_rdata,
    output logic               dmem_re,
    output logic               dmem_we,
    output logic [OPR_W-1:0]   dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               halted
);
    localparam int IW = $clog2(NACC);

    typedef struct packed {
        phase_e             ph;
        logic [IADDR_W-1:0] pc;
        logic [XLEN-1:0]    ir;
    } core_t;

    core_t                  r_d, r_q;
    ctl_t                   ctl;
    logic [XLEN-1:0]        acc_act, alu_y, acc_wd;
    logic [IW-1:0]          act_idx;
    logic [NACC-1:0][XLEN-1:0] acc_all;
    logic                   acc_we, sel_en, take;
    logic [IADDR_W-1:0]     off_ext, br_tgt;

    acc3_decode u_dec (
        .head (r_q.ir[XLEN-1 -: 5]),
        .ctl  (ctl)
    );

    acc3_alu #(.W(XLEN)) u_alu (
        .op (ctl.alu),
        .a  (acc_act),
        .b  (dmem_rdata),
        .y  (alu_y)
    );

    acc3_accbank #(.NACC(NACC), .W(XLEN)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_we),
        .wr_data (acc_wd),
        .sel_en  (sel_en),
        .sel_idx (r_q.ir[IW-1:0]),
        .act_idx (act_idx),
        .acc_all (acc_all)
    );

    // Active accumulator read mux
    always_comb begin
        acc_act = '0;
        for (int i = 0; i < NACC; i++) begin
            if (int'(act_idx) == i) acc_act = acc_all[i];
        end
    end

    // Branch condition and target (relative to the transfer's own address)
    always_comb begin
        case (ctl.cond)
            C_ZERO:    take = (acc_act == '0);
            C_NEG:     take = acc_act[XLEN-1];
            C_NONZERO: take = (acc_act != '0);
            default:   take = 1'b1;
        endcase
        off_ext = {{(IADDR_W-OFF_W){r_q.ir[OFF_W-1]}}, r_q.ir[OFF_W-1:0]};
        br_tgt  = r_q.pc - IADDR_W'(1) + off_ext;
    end

    always_comb begin
        r_d     = r_q;
        acc_we  = 1'b0;
        acc_wd  = alu_y;
        sel_en  = 1'b0;
        dmem_re = 1'b0;
        dmem_we = 1'b0;
        case (r_q.ph)
            S_FETCH: r_d.ph = S_DECODE;
            S_DECODE: begin
                r_d.ir = imem_rdata;
                r_d.pc = r_q.pc + IADDR_W'(1);
                r_d.ph = S_EXEC;
            end
            S_EXEC: begin
                r_d.ph = S_FETCH;
                if (ctl.br && take) r_d.pc = br_tgt;
                if (ctl.ldi) begin
                    acc_we = 1'b1;
                    acc_wd = {{(XLEN-OPR_W){1'b0}}, r_q.ir[OPR_W-1:0]};
                end
                if (ctl.rd) begin
                    dmem_re = 1'b1;
                    r_d.ph  = S_WB;
                end
                if (ctl.st)   dmem_we = 1'b1;
                if (ctl.sel)  sel_en  = 1'b1;
                if (ctl.halt) r_d.ph  = S_HALT;
            end
            S_WB: begin
                acc_we = 1'b1;
                r_d.ph = S_FETCH;
            end
            default: r_d.ph = S_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: S_FETCH, pc: '0, ir: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_en    = (r_q.ph == S_FETCH);
    assign imem_addr  = r_q.pc;
    assign dmem_addr  = r_q.ir[OPR_W-1:0];
    assign dmem_wdata = acc_act;
    assign halted     = (r_q.ph == S_HALT);
endmodule

// File: rtl/acc3_core_chk.sv
module acc3_core_chk #(
    parameter  int NACC = 3,
    parameter  int W    = 16,
    localparam int IW   = $clog2(NACC)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   imem_en,
    input logic                   dmem_re,
    input logic                   dmem_we,
    input logic                   halted,
    input logic [IW-1:0]          act_idx,
    input logic [NACC-1:0][W-1:0] acc_all
);
    a_r6_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(dmem_we && dmem_re));

    a_r6_store_single: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    a_r3_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
        imem_en |=> !imem_en);

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!imem_en && !dmem_we && !dmem_re));

    a_r7_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act_idx) < NACC);

    for (genvar g = 0; g < NACC; g++) begin : g_hold
        a_r7_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (int'($past(act_idx)) != g) |-> $stable(acc_all[g]));
    end
endmodule

bind acc3_core acc3_core_chk #(.NACC(NACC), .W(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .imem_en (imem_en),
    .dmem_re (dmem_re),
    .dmem_we (dmem_we),
    .halted  (halted),
    .act_idx (act_idx),
    .acc_all (acc_all)
);

// File: tb/test_acc3_core.sv
`timescale 1ns/1ps
module test_acc3_core;
    localparam logic [4:0] B_LD = 5'b00001, B_LDI = 5'b00010, B_ST = 5'b00011,
                           B_ADD = 5'b00100, B_SUB = 5'b00101, B_AND = 5'b00110,
                           B_OR = 5'b00111, B_SEL = 5'b01000, B_HALT = 5'b01111;
    localparam logic [2:0] B_JMP = 3'b100, B_BZ = 3'b101, B_BN = 3'b110, B_BNZ = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_en, dmem_re, dmem_we, halted;
    logic [15:0] imem_addr, dmem_wdata;
    logic [15:0] imem_rdata = '0, dmem_rdata = '0;
    logic [10:0] dmem_addr;

    always #5 clk = ~clk;

    acc3_core i_acc3_core (
        .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .dmem_re(dmem_re), .dmem_we(dmem_we),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .halted(halted)
    );

    logic [15:0] prog [256];
    logic [15:0] dmem_m [2048];
    logic [15:0] dinit [2048];
    logic [15:0] iss_m [2048];

    always @(posedge clk) begin
        imem_rdata <= prog[imem_addr[7:0]];
        if (dmem_we) dmem_m[dmem_addr] <= dmem_wdata;
        dmem_rdata <= dmem_m[dmem_addr];
    end

    int total = 0, bad = 0;
    int exp_n, exp_halt, act_n;
    logic [10:0] e_addr [64];
    logic [15:0] e_data [64];
    int          e_t    [64];
    logic [10:0] a_addr [64];
    logic [15:0] a_data [64];
    int          a_t    [64];

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] op(logic [4:0] o, int f);
        logic [10:0] v = 11'(f);
        return {o, v};
    endfunction

    function automatic logic [15:0] br(logic [2:0] o, int off);
        logic [12:0] v = 13'(off);
        return {o, v};
    endfunction

    // Instruction-level model built from the requirements
    task automatic iss();
        logic [15:0] pc = '0;
        logic [15:0] acc [3];
        logic [15:0] ins, v;
        int act = 0, t = 0, n = 0;
        bit done = 0, tk;
        for (int i = 0; i < 3; i++) acc[i] = '0;
        for (int i = 0; i < 2048; i++) iss_m[i] = dinit[i];
        exp_n = 0;
        exp_halt = -1;
        while (!done && n < 2000) begin
            ins = prog[pc[7:0]];
            n++;
            if (ins[15]) begin
                case (ins[15:13])
                    B_BZ:    tk = (acc[act] == 0);
                    B_BN:    tk = acc[act][15];
                    B_BNZ:   tk = (acc[act] != 0);
                    default: tk = 1;
                endcase
                pc = tk ? pc + {{3{ins[12]}}, ins[12:0]} : pc + 1;
                t += 3;
            end else begin
                case (ins[15:11])
                    B_LD, B_ADD, B_SUB, B_AND, B_OR: begin
                        v = iss_m[ins[10:0]];
                        case (ins[15:11])
                            B_ADD:   acc[act] = acc[act] + v;
                            B_SUB:   acc[act] = acc[act] - v;
                            B_AND:   acc[act] = acc[act] & v;
                            B_OR:    acc[act] = acc[act] | v;
                            default: acc[act] = v;
                        endcase
                        t += 4;
                    end
                    B_LDI: begin acc[act] = {5'b0, ins[10:0]}; t += 3; end
                    B_ST: begin
                        if (exp_n < 64) begin
                            e_addr[exp_n] = ins[10:0];
                            e_data[exp_n] = acc[act];
                            e_t[exp_n] = t + 2;
                            exp_n++;
                        end
                        iss_m[ins[10:0]] = acc[act];
                        t += 3;
                    end
                    B_SEL: begin if (ins[1:0] != 2'd3) act = int'(ins[1:0]); t += 3; end
                    B_HALT: begin exp_halt = t + 3; done = 1; end
                    default: t += 3;
                endcase
                pc = pc + 1;
            end
        end
    endtask

    task automatic run_prog(string req);
        int c = 0;
        int halt_c = -1;
        rst_n = 1'b0;
        for (int i = 0; i < 2048; i++) dmem_m[i] = dinit[i];
        iss();
        repeat (2) @(negedge clk);
        chk("R1", "reset imem_addr", int'(imem_addr), 0);
        chk("R1", "reset halted", int'(halted), 0);
        chk("R1", "reset strobes", int'({dmem_we, dmem_re}), 0);
        rst_n = 1'b1;
        #1;
        chk("R1", "first fetch", int'({imem_en, imem_addr}), 32'h10000);
        act_n = 0;
        while (!halted && c < 5000) begin
            @(posedge clk);
            @(negedge clk);
            c++;
            if (dmem_we && act_n < 64) begin
                a_addr[act_n] = dmem_addr;
                a_data[act_n] = dmem_wdata;
                a_t[act_n] = c;
                act_n++;
            end
            if (halted) halt_c = c;
        end
        chk("R10", {req, " halt cycle"}, halt_c, exp_halt);
        chk("R6", {req, " store count"}, act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n; i++) begin
            chk("R3", {req, " store cycle"}, a_t[i], e_t[i]);
            chk(req, "store address", int'(a_addr[i]), int'(e_addr[i]));
            chk(req, "store data", int'(a_data[i]), int'(e_data[i]));
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R10", "after halt", int'({halted, imem_en, dmem_we, dmem_re}), 8);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) prog[i] = op(B_HALT, 0);
        for (int i = 0; i < 2048; i++) dinit[i] = '0;
    endtask

    task automatic gen_random();
        int k;
        clear_mem();
        for (int i = 0; i < 32; i++) dinit[i] = 16'($urandom);
        for (int i = 0; i < 40; i++) begin
            k = int'($urandom % 14);
            case (k)
                0, 1:  prog[i] = op(B_LDI, int'($urandom % 2048));
                2:     prog[i] = op(B_LD, int'($urandom % 32));
                3:     prog[i] = op(B_ADD, int'($urandom % 32));
                4:     prog[i] = op(B_SUB, int'($urandom % 32));
                5:     prog[i] = op(B_AND, int'($urandom % 32));
                6:     prog[i] = op(B_OR, int'($urandom % 32));
                7, 8:  prog[i] = op(B_ST, 32 + int'($urandom % 32));
                9:     prog[i] = op(B_SEL, int'($urandom % 4));
                10, 11: prog[i] = br(3'(4 + $urandom % 4), 1 + int'($urandom % 3));
                12:    prog[i] = op(5'(9 + $urandom % 6), int'($urandom % 2048));
                default: prog[i] = op(5'b00000, int'($urandom % 2048));
            endcase
        end
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R4 R6: immediate extremes stored out
        clear_mem();
        prog[0] = op(B_LDI, 11'h7FF); prog[1] = op(B_ST, 5);
        prog[2] = op(B_LDI, 0);       prog[3] = op(B_ST, 6);
        prog[4] = op(B_HALT, 0);
        run_prog("R4");

        // R5: memory operands, wrap-around
        clear_mem();
        dinit[10] = 16'hFFFF; dinit[11] = 16'h0002; dinit[12] = 16'h0F0F;
        prog[0] = op(B_LD, 10);  prog[1] = op(B_ADD, 11); prog[2] = op(B_ST, 20);
        prog[3] = op(B_LD, 11);  prog[4] = op(B_SUB, 10); prog[5] = op(B_ST, 21);
        prog[6] = op(B_LD, 12);  prog[7] = op(B_AND, 10); prog[8] = op(B_OR, 11);
        prog[9] = op(B_ST, 22);  prog[10] = op(B_HALT, 0);
        run_prog("R5");

        // R7: switching keeps inactive values, selector 3 ignored
        clear_mem();
        prog[0] = op(B_LDI, 5);  prog[1] = op(B_SEL, 1); prog[2] = op(B_LDI, 7);
        prog[3] = op(B_SEL, 2);  prog[4] = op(B_LDI, 9); prog[5] = op(B_SEL, 3);
        prog[6] = op(B_ST, 30);  prog[7] = op(B_SEL, 0); prog[8] = op(B_ST, 31);
        prog[9] = op(B_SEL, 1);  prog[10] = op(B_ST, 32); prog[11] = op(B_HALT, 0);
        run_prog("R7");

        // R8: backward loop and forward jump
        clear_mem();
        dinit[100] = 16'd1;
        prog[0] = op(B_LDI, 3);  prog[1] = op(B_ST, 50); prog[2] = op(B_SUB, 100);
        prog[3] = br(B_BNZ, -2); prog[4] = br(B_JMP, 2); prog[5] = op(B_ST, 51);
        prog[6] = op(B_ST, 52);  prog[7] = op(B_HALT, 0);
        run_prog("R8");

        // R9: taken and untaken conditions
        clear_mem();
        dinit[10] = 16'h8000;
        prog[0] = op(B_LD, 10);  prog[1] = br(B_BZ, 2);  prog[2] = br(B_BN, 2);
        prog[3] = op(B_ST, 60);  prog[4] = op(B_ST, 61); prog[5] = op(B_LDI, 0);
        prog[6] = br(B_BN, 2);   prog[7] = br(B_BZ, 2);  prog[8] = op(B_ST, 62);
        prog[9] = op(B_HALT, 0);
        run_prog("R9");

        // R11: undefined codes are no-ops
        clear_mem();
        prog[0] = op(B_LDI, 33); prog[1] = op(5'b00000, 11'h7FF);
        prog[2] = op(5'b01001, 11'h123); prog[3] = op(5'b01110, 0);
        prog[4] = op(B_ST, 70);  prog[5] = op(B_HALT, 0);
        run_prog("R11");

        // R2: random mixes over the whole encoding
        for (int p = 0; p < 20; p++) begin
            gen_random();
            run_prog("R2");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule